// File: doc/BRIEF.md
# I2C Target Port with Flag-Driven Handshake

This block is the target (slave) side of an I2C bus with a 7-bit own address. It watches SCL and SDA through open-drain pad signals. When a master sends a START and a matching address, the block acknowledges it. It then either accepts data bytes from the master or shifts out bytes that software supplies. Each step of a transfer is reported through a status register. Software clears a status flag by writing 0 to its position.

Software talks to the block through a small register file on a simple write-strobe bus; reads are combinational. While the address-received, data-received or data-empty flag is pending during an addressed session, the block holds SCL low. The master therefore waits until software has handled the byte. The transmit-mode flag is captured together with the address match, so one status read tells software whether to feed bytes or collect them. A control bit can force a NACK on the next received data byte. An interrupt output is raised whenever an enabled status flag is set.

Register map (byte wide): 0 control, 1 status, 2 interrupt enable, 3 own address (bits 6:0), 4 data port (write = byte to send, read = last byte received). Control bits: bit0 forced NACK, bit1 general-call enable, bit2 target enable, bit3 buffer select (stored only). Status bits, with the interrupt-enable register in the same layout: bit0 address matched, bit1 byte received, bit2 byte sent, bit3 send buffer empty, bit4 STOP seen, bit5 master reads (transmit mode), bit6 general call matched.

Top module: `i2c_target_regs`

## Requirements
- R1: After reset all registers read 0, and scl_oe, sda_oe and irq are low.
- R2: An address byte whose bits 7:1 equal the own address is acknowledged with SDA low on the ninth clock, and status bit0 is set. An address byte that does not match gets no ACK and sets no status bit.
- R3: Address 0x00 is acknowledged only when control bit1 is set. It then sets status bit0 and bit6.
- R4: Status bit5 takes the value of the address byte's bit0 (1 = master reads) at the moment the address is matched.
- R5: In a write transfer each received byte can be read from register 4, and status bit1 is set after its ACK bit. The byte gets an ACK unless control bit0 is set, in which case it gets a NACK.
- R6: In a read transfer the byte in register 4 is shifted out MSB first. If the master ACKs it, status bit2 and bit3 are set. If the master NACKs it, only bit2 is set.
- R7: A STOP while addressed sets status bit4. A repeated START followed by a new address match does not set it.
- R8: Writing register 1 clears each status bit whose written bit is 0 and leaves the bits written as 1 unchanged.
- R9: irq is high exactly when some status bit and the same interrupt-enable bit are both set.
- R10: While addressed, SCL is held low as long as status bit0, bit1 or bit3 is set, and it is released once software clears them.
- R11: While control bit2 is 0 the block ignores the bus: it gives no ACK and sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register select |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle. SDA is driven only in acknowledge or send phases. A status bit falls only through a register write or a new address match. The general-call match depends on the enable bit, and the STOP flag rises only after an addressed session. The reset state is clean, and irq stays low with all enables off. The bench's bus scenarios are the only place to show the byte values on the wire, the ACK/NACK choice, the exact flag patterns after each phase, SCL stretching seen on the wired line, and the difference between a repeated START and a STOP.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR7_W = 7;
    localparam int STAT_W  = 7;
    localparam int CTRL_W  = 4;
    localparam int CNT_W   = $clog2(BYTE_W);

    // status bit positions (interrupt-enable uses the same layout)
    localparam int SB_ADDR   = 0;
    localparam int SB_RXD    = 1;
    localparam int SB_TXD    = 2;
    localparam int SB_TXE    = 3;
    localparam int SB_STOP   = 4;
    localparam int SB_TXMODE = 5;
    localparam int SB_GCALL  = 6;

    // control bit positions
    localparam int CB_FNACK  = 0;
    localparam int CB_GCEN   = 1;
    localparam int CB_EN     = 2;
    localparam int CB_BUFSEL = 3;

    typedef enum logic [2:0] {
        RS_CTRL  = 3'd0,
        RS_STAT  = 3'd1,
        RS_IEN   = 3'd2,
        RS_OADDR = 3'd3,
        RS_DATA  = 3'd4
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACKA,
        ST_RX,
        ST_ACKR,
        ST_TXW,
        ST_TX,
        ST_ACKT
    } eng_st_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } line_ev_t;

    typedef struct packed {
        logic addr;
        logic gcall;
        logic dir;
        logic rxd;
        logic txd;
        logic txe;
        logic stop;
    } eng_ev_t;

    function automatic logic is_gcall(input logic [ADDR7_W-1:0] a);
        return a == '0;
    endfunction

    function automatic logic addr_hit(input logic [ADDR7_W-1:0] a,
                                      input logic [ADDR7_W-1:0] own,
                                      input logic               gc_en);
        return is_gcall(a) ? gc_en : (a == own);
    endfunction

endpackage

// File: rtl/i2c_tgt_line_mon.sv
module i2c_tgt_line_mon
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
    logic scl_d, sda_d;
    logic scl_s, sda_s;

    assign scl_s = scl_sync[LAST];
    assign sda_s = sda_sync[LAST];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
        ev.sda      = sda_s;
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               gc_en,
    input  logic               fnack,
    input  logic [ADDR7_W-1:0] own_addr,
    input  logic               hold,
    input  logic [BYTE_W-1:0]  tx_byte,
    input  line_ev_t           lv,
    output eng_ev_t            ev,
    output logic [BYTE_W-1:0]  rx_byte,
    output logic               sda_oe,
    output logic               addressed
);
    eng_st_e            st_q;
    logic [BYTE_W-1:0]  shreg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               done_q;
    logic               ack_seen_q;
    logic               dir_q;
    logic               gc_q;
    logic               sda_oe_q;
    logic               addressed_q;
    logic [BYTE_W-1:0]  rx_q;
    eng_ev_t            ev_q;

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            shreg_q     <= '0;
            cnt_q       <= '0;
            done_q      <= 1'b0;
            ack_seen_q  <= 1'b0;
            dir_q       <= 1'b0;
            gc_q        <= 1'b0;
            sda_oe_q    <= 1'b0;
            addressed_q <= 1'b0;
            rx_q        <= '0;
            ev_q        <= '0;
        end else begin
            ev_q <= '0;
            if (!en) begin
                st_q        <= ST_IDLE;
                sda_oe_q    <= 1'b0;
                addressed_q <= 1'b0;
            end else if (lv.start) begin
                st_q        <= ST_ADDR;
                cnt_q       <= '0;
                done_q      <= 1'b0;
                sda_oe_q    <= 1'b0;
                addressed_q <= 1'b0;
            end else if (lv.stop) begin
                st_q        <= ST_IDLE;
                sda_oe_q    <= 1'b0;
                ev_q.stop   <= addressed_q;
                addressed_q <= 1'b0;
            end else begin
                case (st_q)
                    ST_ADDR, ST_RX: begin
                        if (lv.scl_rise) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], lv.sda};
                            cnt_q   <= cnt_q + 1'b1;
                            if (cnt_q == CNT_LAST) done_q <= 1'b1;
                        end else if (lv.scl_fall && done_q) begin
                            done_q <= 1'b0;
                            cnt_q  <= '0;
                            if (st_q == ST_ADDR) begin
                                if (addr_hit(shreg_q[BYTE_W-1:1], own_addr, gc_en)) begin
                                    st_q     <= ST_ACKA;
                                    sda_oe_q <= 1'b1;
                                    dir_q    <= shreg_q[0];
                                    gc_q     <= is_gcall(shreg_q[BYTE_W-1:1]);
                                end else begin
                                    st_q <= ST_IDLE;
                                end
                            end else begin
                                st_q     <= ST_ACKR;
                                sda_oe_q <= ~fnack;
                                rx_q     <= shreg_q;
                            end
                        end
                    end
                    ST_ACKA: begin
                        if (lv.scl_fall) begin
                            sda_oe_q    <= 1'b0;
                            addressed_q <= 1'b1;
                            ev_q.addr   <= 1'b1;
                            ev_q.gcall  <= gc_q;
                            ev_q.dir    <= dir_q;
                            st_q        <= dir_q ? ST_TXW : ST_RX;
                        end
                    end
                    ST_ACKR: begin
                        if (lv.scl_fall) begin
                            sda_oe_q <= 1'b0;
                            ev_q.rxd <= 1'b1;
                            st_q     <= ST_RX;
                        end
                    end
                    ST_TXW: begin
                        if (!hold) begin
                            shreg_q  <= tx_byte;
                            sda_oe_q <= ~tx_byte[BYTE_W-1];
                            cnt_q    <= '0;
                            st_q     <= ST_TX;
                        end
                    end
                    ST_TX: begin
                        if (lv.scl_fall) begin
                            if (cnt_q == CNT_LAST) begin
                                st_q     <= ST_ACKT;
                                sda_oe_q <= 1'b0;
                            end else begin
                                shreg_q  <= {shreg_q[BYTE_W-2:0], 1'b0};
                                sda_oe_q <= ~shreg_q[BYTE_W-2];
                                cnt_q    <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_ACKT: begin
                        if (lv.scl_rise) begin
                            ack_seen_q <= ~lv.sda;
                        end else if (lv.scl_fall) begin
                            ev_q.txd <= 1'b1;
                            if (ack_seen_q) begin
                                ev_q.txe <= 1'b1;
                                st_q     <= ST_TXW;
                            end else begin
                                st_q <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ev        = ev_q;
    assign rx_byte   = rx_q;
    assign sda_oe    = sda_oe_q;
    assign addressed = addressed_q;

    // R2
    sda_drive_chk: assert property (@(posedge clk) disable iff (rst)
        sda_oe_q |-> (st_q == ST_ACKA || st_q == ST_ACKR || st_q == ST_TX));

    // R3
    gc_accept_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(st_q == ST_ACKA) && gc_q) |-> $past(gc_en));

    // R7
    stop_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ev_q.stop |-> $past(addressed_q));

    // R10
    tx_wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TXW && hold && en && !lv.start && !lv.stop) |=> st_q == ST_TXW);

endmodule

// File: rtl/i2c_target_regs.sv
module i2c_target_regs
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              irq
);
    logic [CTRL_W-1:0]  ctrl_q;
    logic [STAT_W-1:0]  stat_q, stat_n;
    logic [STAT_W-1:0]  ien_q;
    logic [ADDR7_W-1:0] oaddr_q;
    logic [BYTE_W-1:0]  txbuf_q;

    line_ev_t           lv;
    eng_ev_t            ev;
    logic [BYTE_W-1:0]  rx_byte;
    logic               addressed;
    logic               hold;

    logic wr_ctrl, wr_stat, wr_ien, wr_oaddr, wr_data;

    assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(RS_CTRL));
    assign wr_stat  = bus_we && (bus_addr == ADDR_W'(RS_STAT));
    assign wr_ien   = bus_we && (bus_addr == ADDR_W'(RS_IEN));
    assign wr_oaddr = bus_we && (bus_addr == ADDR_W'(RS_OADDR));
    assign wr_data  = bus_we && (bus_addr == ADDR_W'(RS_DATA));

    i2c_tgt_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (lv)
    );

    // pending flags, including events not yet folded into status
    assign hold = stat_q[SB_ADDR] | stat_q[SB_TXE] | ev.addr | ev.txe;

    i2c_tgt_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl_q[CB_EN]),
        .gc_en     (ctrl_q[CB_GCEN]),
        .fnack     (ctrl_q[CB_FNACK]),
        .own_addr  (oaddr_q),
        .hold      (hold),
        .tx_byte   (txbuf_q),
        .lv        (lv),
        .ev        (ev),
        .rx_byte   (rx_byte),
        .sda_oe    (sda_oe),
        .addressed (addressed)
    );

    always_comb begin
        stat_n = stat_q;
        if (wr_stat) stat_n = stat_q & bus_wdata[STAT_W-1:0];
        if (ev.addr) begin
            stat_n[SB_ADDR]   = 1'b1;
            stat_n[SB_TXMODE] = ev.dir;
            stat_n[SB_GCALL]  = ev.gcall;
        end
        if (ev.rxd)  stat_n[SB_RXD]  = 1'b1;
        if (ev.txd)  stat_n[SB_TXD]  = 1'b1;
        if (ev.txe)  stat_n[SB_TXE]  = 1'b1;
        if (ev.stop) stat_n[SB_STOP] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            stat_q  <= '0;
            ien_q   <= '0;
            oaddr_q <= '0;
            txbuf_q <= '0;
        end else begin
            stat_q <= stat_n;
            if (wr_ctrl)  ctrl_q  <= bus_wdata[CTRL_W-1:0];
            if (wr_ien)   ien_q   <= bus_wdata[STAT_W-1:0];
            if (wr_oaddr) oaddr_q <= bus_wdata[ADDR7_W-1:0];
            if (wr_data)  txbuf_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(RS_CTRL))       bus_rdata = 8'(ctrl_q);
        else if (bus_addr == ADDR_W'(RS_STAT))  bus_rdata = 8'(stat_q);
        else if (bus_addr == ADDR_W'(RS_IEN))   bus_rdata = 8'(ien_q);
        else if (bus_addr == ADDR_W'(RS_OADDR)) bus_rdata = 8'(oaddr_q);
        else if (bus_addr == ADDR_W'(RS_DATA))  bus_rdata = rx_byte;
    end

    assign scl_oe = addressed & (stat_q[SB_ADDR] | stat_q[SB_RXD] | stat_q[SB_TXE]);
    assign irq    = |(stat_q & ien_q);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stat_q == '0 && !scl_oe && !irq));

    // R8
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (|($past(stat_q) & ~stat_q)) |-> ($past(wr_stat) || $past(ev.addr)));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq);

endmodule

// File: tb/tb_i2c_target_regs.sv
module tb_i2c_target_regs;

    localparam int T = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       scl_oe, sda_oe, irq;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       scl_line, sda_line;

    int total = 0;
    int bad   = 0;

    assign scl_line = !(m_scl_low || scl_oe);
    assign sda_line = !(m_sda_low || sda_oe);

    always #5 clk = ~clk;

    i2c_target_regs dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .scl_i     (scl_line),
        .sda_i     (sda_line),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .irq       (irq)
    );

    typedef struct packed {
        logic [6:0] oa;
        logic [6:0] ta;
        logic [7:0] dat;
        logic       fnack;
        logic       gcen;
        logic       ack_a;
        logic       ack_d;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{7'h2A, 7'h2A, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b1},
        '{7'h2A, 7'h2B, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0},
        '{7'h55, 7'h55, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b0},
        '{7'h10, 7'h00, 8'hC3, 1'b0, 1'b1, 1'b1, 1'b1},
        '{7'h10, 7'h00, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0},
        '{7'h7F, 7'h7F, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic hp();
        repeat (T) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl_low = 1'b0;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda_low = 1'b0; hp();
        scl_up(); hp();
        m_sda_low = 1'b1; hp();
        m_scl_low = 1'b1; hp();
    endtask

    task automatic i2c_stop();
        m_sda_low = 1'b1; hp();
        scl_up(); hp();
        m_sda_low = 1'b0; hp();
    endtask

    task automatic put_bit(input logic b);
        m_sda_low = !b; hp();
        scl_up(); hp();
        m_scl_low = 1'b1; hp();
    endtask

    task automatic get_bit(output logic b);
        m_sda_low = 1'b0; hp();
        scl_up(); hp();
        b = sda_line;
        m_scl_low = 1'b1; hp();
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic rd_byte(output logic [7:0] d, input logic ack);
        logic b;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            d = {d[6:0], b};
        end
        put_bit(!ack);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=%h exp=%h", 1'b1, 1'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic       ack;
        logic [7:0] gcb;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        reg_rd(3'd0, r); chk("R1 ctrl", r, 8'h00);
        reg_rd(3'd1, r); chk("R1 stat", r, 8'h00);
        reg_rd(3'd2, r); chk("R1 ien", r, 8'h00);
        reg_rd(3'd3, r); chk("R1 oaddr", r, 8'h00);
        chk("R1 pins", {5'b0, scl_oe, sda_oe, irq}, 8'h00);

        // table of write transfers: R2 R3 R4 R5 R7
        for (int k = 0; k < NV; k++) begin
            reg_wr(3'd0, {5'b0, 1'b1, VEC[k].gcen, VEC[k].fnack});
            reg_wr(3'd3, {1'b0, VEC[k].oa});
            reg_wr(3'd1, 8'h00);
            gcb = (VEC[k].ta == 7'h00) ? 8'h40 : 8'h00;
            i2c_start();
            wr_byte({VEC[k].ta, 1'b0}, ack);
            chk("R2/R3 addr ack", {7'b0, ack}, {7'b0, VEC[k].ack_a});
            if (VEC[k].ack_a) begin
                reg_rd(3'd1, r); chk("R2/R3/R4 addr stat", r, 8'h01 | gcb);
                reg_wr(3'd1, 8'hFE);
                wr_byte(VEC[k].dat, ack);
                chk("R5 data ack", {7'b0, ack}, {7'b0, VEC[k].ack_d});
                reg_rd(3'd1, r); chk("R5 rx stat", r, 8'h02 | gcb);
                reg_rd(3'd4, r); chk("R5 rx data", r, VEC[k].dat);
                reg_wr(3'd1, 8'hFD);
                i2c_stop();
                reg_rd(3'd1, r); chk("R7 stop stat", r, 8'h10 | gcb);
            end else begin
                i2c_stop();
                reg_rd(3'd1, r); chk("R2/R3 ignored stat", r, 8'h00);
            end
        end

        // R4 R6 R10 read transfer
        reg_wr(3'd0, 8'h04);
        reg_wr(3'd3, 8'h33);
        reg_wr(3'd1, 8'h00);
        i2c_start();
        wr_byte({7'h33, 1'b1}, ack);
        chk("R2 read addr ack", {7'b0, ack}, 8'h01);
        reg_rd(3'd1, r); chk("R4 txmode stat", r, 8'h21);
        m_scl_low = 1'b0;
        repeat (30) @(negedge clk);
        chk("R10 scl held", {7'b0, scl_line}, 8'h00);
        m_scl_low = 1'b1;
        reg_wr(3'd4, 8'h96);
        reg_wr(3'd1, 8'hFE);
        repeat (2) @(negedge clk);
        chk("R10 scl released", {7'b0, scl_oe}, 8'h00);
        rd_byte(r, 1'b1); chk("R6 first byte", r, 8'h96);
        reg_rd(3'd1, r); chk("R6 ack stat", r, 8'h2C);
        reg_wr(3'd4, 8'h4B);
        reg_wr(3'd1, 8'hF3);
        rd_byte(r, 1'b0); chk("R6 second byte", r, 8'h4B);
        reg_rd(3'd1, r); chk("R6 nack stat", r, 8'h24);
        i2c_stop();
        reg_rd(3'd1, r); chk("R7 stop after read", r, 8'h34);

        // R8 write-one keeps, write-zero clears
        reg_wr(3'd1, 8'hFF);
        reg_rd(3'd1, r); chk("R8 write ones", r, 8'h34);
        reg_wr(3'd1, 8'hEF);
        reg_rd(3'd1, r); chk("R8 clear stop", r, 8'h24);
        reg_wr(3'd1, 8'h00);
        reg_rd(3'd1, r); chk("R8 clear all", r, 8'h00);

        // R9 interrupt, then R7 repeated start
        reg_wr(3'd2, 8'h01);
        chk("R9 irq idle", {7'b0, irq}, 8'h00);
        i2c_start();
        wr_byte({7'h33, 1'b0}, ack);
        @(negedge clk);
        chk("R9 irq on match", {7'b0, irq}, 8'h01);
        reg_wr(3'd2, 8'h10);
        chk("R9 irq masked", {7'b0, irq}, 8'h00);
        reg_wr(3'd2, 8'h01);
        reg_wr(3'd1, 8'hFE);
        chk("R9 irq cleared", {7'b0, irq}, 8'h00);
        wr_byte(8'h5A, ack);
        reg_rd(3'd4, r); chk("R5 rx before restart", r, 8'h5A);
        reg_wr(3'd1, 8'hFD);
        i2c_start();
        wr_byte({7'h33, 1'b1}, ack);
        reg_rd(3'd1, r); chk("R7 restart no stop", r, 8'h21);
        reg_wr(3'd4, 8'hFF);
        reg_wr(3'd1, 8'hFE);
        rd_byte(r, 1'b0);
        i2c_stop();
        reg_wr(3'd1, 8'h00);
        reg_wr(3'd2, 8'h00);

        // R11 disabled target
        reg_wr(3'd0, 8'h00);
        i2c_start();
        wr_byte({7'h33, 1'b0}, ack);
        chk("R11 no ack", {7'b0, ack}, 8'h00);
        i2c_stop();
        reg_rd(3'd1, r); chk("R11 stat", r, 8'h00);
        chk("R11 scl free", {7'b0, scl_oe}, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule